// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits between the local processor bus and a PCI bus master and decides, for each local request address, which of three programmable outbound windows it falls into. It then produces the PCI address that the request should use. Software programs the windows through a small 32-bit register port. The block reports hit, window number and translated address one clock after each request strobe.

Windows 0 and 1 each hold a 64-bit local base, a 64-bit PCI base and a 32-bit size/attribute word. Window 2 has only a size/attribute word, and both of its bases are fixed at zero. Bit 0 of a size/attribute word enables its window. The remaining bits give the span of the window: the span is the 32-bit two's complement of the word with bit 0 cleared, and a result of zero means a span of 0xFFFFFFFF. The PCI bus protocol, data transfer and the reaction to a miss belong to other blocks.

Top module: `obwin_xlate`

## Requirements
- R1: After reset every window register reads as zero, so all windows are disabled, and rspValid, rspHit, rspMiss, rspIdx and rspPciAddr are all zero.
- R2: Registers sit at these byte offsets. Window 0: local low 0x68, local high 0x6C, size/attribute 0x70, PCI low 0x74, PCI high 0x78. Window 1: local low 0x7C, local high 0x80, size/attribute 0x84, PCI low 0x88, PCI high 0x8C. Window 2: size/attribute 0x90. regRdata combinationally returns the register selected by regAddr. Any other offset reads as zero, and a write to it changes no register.
- R3: Writing the low half of a 64-bit base keeps its upper 32 bits. Writing the high half keeps its lower 32 bits.
- R4: A window whose size/attribute bit 0 is clear never hits.
- R5: The window span is the 32-bit value `~(sa & 0xFFFFFFFE) + 1`, and 0 is replaced by 0xFFFFFFFF. A request hits an enabled window when the 64-bit wrapping difference (reqAddr − local base) is below the span.
- R6: On a hit, rspPciAddr equals the PCI base plus (reqAddr − local base), modulo 2^64.
- R7: When several windows hit, the lowest-numbered one wins. rspIdx carries its number as 0, 1 or 2.
- R8: When no window hits, rspMiss is 1, rspHit is 0, and rspIdx and rspPciAddr are zero. rspHit and rspMiss are never both 1.
- R9: Window 2 uses a local base and a PCI base of zero and is decoded from its own size/attribute word.
- R10: rspValid is high exactly in the cycle after a cycle with reqValid high. The response fields are updated on that edge and hold their values until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data of the register at regAddr |
| reqValid | input | 1 | Request address strobe |
| reqAddr | input | 64 | Local request address |
| rspValid | output | 1 | Response strobe, one cycle after reqValid |
| rspHit | output | 1 | Request fell in an enabled window |
| rspMiss | output | 1 | Request fell in no window |
| rspIdx | output | 2 | Number of the winning window |
| rspPciAddr | output | 64 | Translated PCI address |

## Verification
Register readback is combinational. The bench sets regAddr on a falling edge and compares regRdata a short delay later in the same cycle. A register write takes effect at the rising edge that follows the falling edge where it was driven. The translation result is one register stage deep. The bench raises reqValid on a falling edge and reads rspValid, rspHit, rspMiss, rspIdx and rspPciAddr on the next falling edge, which is half a cycle after the capturing edge. One falling edge later it confirms that rspValid has dropped and that the result fields have held.

// File: rtl/obwin_pkg.sv
package obwin_pkg;
  localparam int NUM_WIN  = 3;
  localparam int NUM_FULL = 2;
  localparam int REG_AW   = 8;
  localparam int DW       = 32;
  localparam int AW       = 64;
  localparam int IDX_W    = $clog2(NUM_WIN);

  localparam logic [REG_AW-1:0] BASE_OFS    = 8'h68;
  localparam logic [REG_AW-1:0] WIN_STRIDE  = 8'h14;
  localparam logic [REG_AW-1:0] LAST_SA_OFS = 8'h90;

  typedef enum logic [2:0] {
    F_LALO = 3'd0,
    F_LAHI = 3'd1,
    F_SA   = 3'd2,
    F_PCLO = 3'd3,
    F_PCHI = 3'd4
  } field_e;

  typedef struct packed {
    logic [NUM_WIN-1:0] laLo;
    logic [NUM_WIN-1:0] laHi;
    logic [NUM_WIN-1:0] sa;
    logic [NUM_WIN-1:0] pcLo;
    logic [NUM_WIN-1:0] pcHi;
    logic               capture;
  } wrStrobe_t;

  typedef struct packed {
    logic             valid;
    logic [IDX_W-1:0] win;
    field_e           fld;
  } rdSel_t;

  function automatic logic [DW-1:0] winSpan(input logic [DW-1:0] sa);
    logic [DW-1:0] s;
    s = ~(sa & ~DW'(1)) + DW'(1);
    if (s == '0) s = '1;
    return s;
  endfunction
endpackage

// File: rtl/obwin_ctrl.sv
module obwin_ctrl
  import obwin_pkg::*;
(
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              reqValid,
  output wrStrobe_t         ctl,
  output rdSel_t            sel
);
  logic [REG_AW-1:0] offs;

  always_comb begin
    sel  = '0;
    offs = '0;
    for (int w = 0; w < NUM_FULL; w++) begin
      offs = regAddr - REG_AW'(BASE_OFS + REG_AW'(w) * WIN_STRIDE);
      if (offs < WIN_STRIDE && offs[1:0] == 2'b00) begin
        sel.valid = 1'b1;
        sel.win   = IDX_W'(w);
        sel.fld   = field_e'(offs[4:2]);
      end
    end
    if (regAddr == LAST_SA_OFS) begin
      sel.valid = 1'b1;
      sel.win   = IDX_W'(NUM_WIN - 1);
      sel.fld   = F_SA;
    end
  end

  always_comb begin
    ctl = '0;
    ctl.capture = reqValid;
    if (regWrEn && sel.valid) begin
      case (sel.fld)
        F_LALO:  ctl.laLo[sel.win] = 1'b1;
        F_LAHI:  ctl.laHi[sel.win] = 1'b1;
        F_SA:    ctl.sa[sel.win]   = 1'b1;
        F_PCLO:  ctl.pcLo[sel.win] = 1'b1;
        F_PCHI:  ctl.pcHi[sel.win] = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/obwin_match.sv
module obwin_match
  import obwin_pkg::*;
(
  input  logic [AW-1:0] localBase,
  input  logic [AW-1:0] pciBase,
  input  logic [DW-1:0] sizeAttr,
  input  logic [AW-1:0] reqAddr,
  output logic          hit,
  output logic [AW-1:0] xlat
);
  logic [AW-1:0] offset;
  logic [DW-1:0] span;

  assign offset = reqAddr - localBase;
  assign span   = winSpan(sizeAttr);
  assign hit    = sizeAttr[0] && (offset < {{(AW-DW){1'b0}}, span});
  assign xlat   = pciBase + offset;
endmodule

// File: rtl/obwin_dp.sv
module obwin_dp
  import obwin_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  wrStrobe_t        ctl,
  input  rdSel_t           sel,
  input  logic [DW-1:0]    regWdata,
  output logic [DW-1:0]    regRdata,
  input  logic [AW-1:0]    reqAddr,
  output logic             rspValid,
  output logic             rspHit,
  output logic             rspMiss,
  output logic [IDX_W-1:0] rspIdx,
  output logic [AW-1:0]    rspPciAddr
);
  logic [NUM_WIN-1:0][AW-1:0] laVec;
  logic [NUM_WIN-1:0][AW-1:0] pcVec;
  logic [NUM_WIN-1:0][DW-1:0] saVec;
  logic [NUM_WIN-1:0][AW-1:0] xlatVec;
  logic [NUM_WIN-1:0]         hitVec;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [DW-1:0] saQ;
    always_ff @(posedge clk) begin
      if (!rstN)           saQ <= '0;
      else if (ctl.sa[w])  saQ <= regWdata;
    end
    assign saVec[w] = saQ;

    if (w < NUM_FULL) begin : g_full
      logic [AW-1:0] laQ;
      logic [AW-1:0] pcQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          laQ <= '0;
          pcQ <= '0;
        end else begin
          if (ctl.laLo[w]) laQ[DW-1:0]  <= regWdata;
          if (ctl.laHi[w]) laQ[AW-1:DW] <= regWdata;
          if (ctl.pcLo[w]) pcQ[DW-1:0]  <= regWdata;
          if (ctl.pcHi[w]) pcQ[AW-1:DW] <= regWdata;
        end
      end
      assign laVec[w] = laQ;
      assign pcVec[w] = pcQ;
    end else begin : g_fixed
      assign laVec[w] = '0;
      assign pcVec[w] = '0;
    end

    obwin_match u_match (
      .localBase (laVec[w]),
      .pciBase   (pcVec[w]),
      .sizeAttr  (saVec[w]),
      .reqAddr   (reqAddr),
      .hit       (hitVec[w]),
      .xlat      (xlatVec[w])
    );
  end

  // readback mux
  always_comb begin
    regRdata = '0;
    if (sel.valid) begin
      case (sel.fld)
        F_LALO:  regRdata = laVec[sel.win][DW-1:0];
        F_LAHI:  regRdata = laVec[sel.win][AW-1:DW];
        F_SA:    regRdata = saVec[sel.win];
        F_PCLO:  regRdata = pcVec[sel.win][DW-1:0];
        F_PCHI:  regRdata = pcVec[sel.win][AW-1:DW];
        default: regRdata = '0;
      endcase
    end
  end

  // lowest index wins
  logic             anyHit;
  logic [IDX_W-1:0] winIdx;
  always_comb begin
    anyHit = 1'b0;
    winIdx = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hitVec[w]) begin
        anyHit = 1'b1;
        winIdx = IDX_W'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspHit     <= 1'b0;
      rspMiss    <= 1'b0;
      rspIdx     <= '0;
      rspPciAddr <= '0;
    end else begin
      rspValid <= ctl.capture;
      if (ctl.capture) begin
        rspHit     <= anyHit;
        rspMiss    <= !anyHit;
        rspIdx     <= anyHit ? winIdx : '0;
        rspPciAddr <= anyHit ? xlatVec[winIdx] : '0;
      end
    end
  end
endmodule

// File: rtl/obwin_xlate.sv
module obwin_xlate
  import obwin_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DW-1:0]     regWdata,
  output logic [DW-1:0]     regRdata,
  input  logic              reqValid,
  input  logic [AW-1:0]     reqAddr,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMiss,
  output logic [IDX_W-1:0]  rspIdx,
  output logic [AW-1:0]     rspPciAddr
);
  wrStrobe_t ctl;
  rdSel_t    sel;

  obwin_ctrl u_ctrl (
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .reqValid (reqValid),
    .ctl      (ctl),
    .sel      (sel)
  );

  obwin_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .sel        (sel),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .reqAddr    (reqAddr),
    .rspValid   (rspValid),
    .rspHit     (rspHit),
    .rspMiss    (rspMiss),
    .rspIdx     (rspIdx),
    .rspPciAddr (rspPciAddr)
  );
endmodule

// File: rtl/obwin_xlate_chk.sv
module obwin_xlate_chk (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  regAddr,
  input logic        regWrEn,
  input logic [31:0] regWdata,
  input logic [31:0] regRdata,
  input logic        reqValid,
  input logic [63:0] reqAddr,
  input logic        rspValid,
  input logic        rspHit,
  input logic        rspMiss,
  input logic [1:0]  rspIdx,
  input logic [63:0] rspPciAddr
);
  logic isMapped;
  assign isMapped = (regAddr >= 8'h68) && (regAddr <= 8'h90) && (regAddr[1:0] == 2'b00);

  // R2: unmapped offsets read zero
  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !isMapped |-> regRdata == 32'h0);

  // R2: a written register reads back its value on the next cycle
  p_readback_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && isMapped) |=> (regAddr != $past(regAddr) || regRdata == $past(regWdata)));

  // R10: response strobe timing
  p_rsp_follows_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_no_spurious_rsp_r10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(rspPciAddr) && $stable(rspHit) && $stable(rspIdx) && $stable(rspMiss)));

  // R8: miss output is clean, hit and miss exclusive
  p_miss_clean_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspMiss |-> (!rspHit && rspPciAddr == 64'h0 && rspIdx == 2'd0));

  // R7: window number in range
  p_idx_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> rspIdx != 2'd3);
endmodule

bind obwin_xlate obwin_xlate_chk u_chk (.*);

// File: tb/obwin_xlate_bench.sv
module obwin_xlate_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  regAddr;
  logic        regWrEn;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic        reqValid;
  logic [63:0] reqAddr;
  logic        rspValid;
  logic        rspHit;
  logic        rspMiss;
  logic [1:0]  rspIdx;
  logic [63:0] rspPciAddr;

  int nChk = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  obwin_xlate u_obwin_xlate (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(tag, {32'h0, regRdata}, {32'h0, exp});
  endtask

  task automatic sendReq(input logic [63:0] a);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expRsp(input string tag, input logic hit, input logic [1:0] idx, input logic [63:0] addr);
    chk({tag, " R10 valid"}, {63'h0, rspValid}, 64'h1);
    chk({tag, " hit"},  {63'h0, rspHit},  {63'h0, hit});
    chk({tag, " R8 miss"}, {63'h0, rspMiss}, {63'h0, !hit});
    chk({tag, " idx"},  {62'h0, rspIdx},  {62'h0, idx});
    chk({tag, " addr"}, rspPciAddr, addr);
  endtask

  task automatic t_reset();
    chk("R1 rspValid", {63'h0, rspValid}, 64'h0);
    chk("R1 rspHit", {63'h0, rspHit}, 64'h0);
    chk("R1 rspMiss", {63'h0, rspMiss}, 64'h0);
    chk("R1 rspAddr", rspPciAddr, 64'h0);
    for (int a = 8'h68; a <= 8'h90; a += 4) rdChk("R1 reg zero", 8'(a), 32'h0);
  endtask

  task automatic t_readback();
    for (int a = 8'h68; a <= 8'h90; a += 4) wrReg(8'(a), 32'hA500_0000 | 32'(a));
    for (int a = 8'h68; a <= 8'h90; a += 4) rdChk("R2 readback", 8'(a), 32'hA500_0000 | 32'(a));
    wrReg(8'h94, 32'hDEAD_BEEF);
    wrReg(8'h00, 32'hDEAD_BEEF);
    rdChk("R2 unmapped 0x94", 8'h94, 32'h0);
    rdChk("R2 unmapped 0x00", 8'h00, 32'h0);
    rdChk("R2 neighbour kept", 8'h90, 32'hA500_0090);
    rdChk("R2 first kept", 8'h68, 32'hA500_0068);
  endtask

  task automatic t_halves();
    wrReg(8'h68, 32'h1111_1111);
    rdChk("R3 high kept", 8'h6C, 32'hA500_006C);
    wrReg(8'h78, 32'h2222_2222);
    rdChk("R3 low kept", 8'h74, 32'hA500_0074);
    rdChk("R3 low new", 8'h68, 32'h1111_1111);
    wrReg(8'h70, 32'h0); wrReg(8'h84, 32'h0); wrReg(8'h90, 32'h0);
  endtask

  task automatic t_translate();
    wrReg(8'h68, 32'h8000_0000); wrReg(8'h6C, 32'h1);
    wrReg(8'h74, 32'hC000_0000); wrReg(8'h78, 32'h0);
    wrReg(8'h70, 32'hFFFF_0001);
    sendReq(64'h1_8000_1234); expRsp("R5 R6 in window", 1, 0, 64'hC000_1234);
    sendReq(64'h1_8000_FFFF); expRsp("R5 last byte", 1, 0, 64'hC000_FFFF);
    sendReq(64'h1_8001_0000); expRsp("R5 one past end", 0, 0, 64'h0);
    sendReq(64'h1_7FFF_FFFF); expRsp("R5 below base", 0, 0, 64'h0);
  endtask

  task automatic t_enable();
    wrReg(8'h70, 32'hFFFF_0000);
    sendReq(64'h1_8000_1234); expRsp("R4 disabled", 0, 0, 64'h0);
  endtask

  task automatic t_fullspan();
    wrReg(8'h7C, 32'h0); wrReg(8'h80, 32'h2);
    wrReg(8'h88, 32'h0); wrReg(8'h8C, 32'h10);
    wrReg(8'h84, 32'h0000_0001);
    sendReq(64'h2_FFFF_FFFE); expRsp("R5 zero span remap", 1, 1, 64'h10_FFFF_FFFE);
    sendReq(64'h2_FFFF_FFFF); expRsp("R5 span limit", 0, 0, 64'h0);
  endtask

  task automatic t_priority();
    wrReg(8'h70, 32'hFFFF_0001);
    wrReg(8'h7C, 32'h8000_0000); wrReg(8'h80, 32'h1);
    wrReg(8'h88, 32'h0); wrReg(8'h8C, 32'h20);
    wrReg(8'h84, 32'hFFF0_0001);
    sendReq(64'h1_8000_0010); expRsp("R7 overlap lowest", 1, 0, 64'hC000_0010);
    sendReq(64'h1_8002_0000); expRsp("R7 only window 1", 1, 1, 64'h20_0002_0000);
  endtask

  task automatic t_win2();
    wrReg(8'h90, 32'hF000_0001);
    sendReq(64'h0800_0000); expRsp("R9 window 2", 1, 2, 64'h0800_0000);
    sendReq(64'h1000_0000); expRsp("R9 R8 past window 2", 0, 0, 64'h0);
    sendReq(64'h0000_0040); expRsp("R9 low edge", 1, 2, 64'h0000_0040);
  endtask

  task automatic t_timing();
    @(negedge clk);
    chk("R10 strobe drops", {63'h0, rspValid}, 64'h0);
    chk("R10 addr held", rspPciAddr, 64'h0000_0040);
    chk("R10 idx held", {62'h0, rspIdx}, 64'h2);
    regAddr = 8'h70; regWdata = 32'h0; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    chk("R10 held over write", {63'h0, rspHit}, 64'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++; nErr++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; regAddr = 8'h0; regWrEn = 1'b0; regWdata = 32'h0;
    reqValid = 1'b0; reqAddr = 64'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_readback();
    t_halves();
    t_translate();
    t_enable();
    t_fullspan();
    t_priority();
    t_win2();
    t_timing();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule